// File: doc/BRIEF.md
# Synthesizer Divider and Phase-Frequency Detector Core

This block is the digital heart of an integer-N frequency synthesizer. A main divider counts edges of the prescaled RF signal and divides by a fixed base of 2176 plus a 7-bit programmed offset, which gives ratios from 2176 to 2303. A reference divider counts crystal edges and divides by 4, 8, 12 or 16, chosen by a 2-bit code. A phase-frequency detector compares the two divided edges and drives an up (source) and a down (sink) request toward an external charge pump. The pulse width tracks the time between the two edges.

Both incoming clocks are seen as single-cycle tick strobes in one fast core clock, so every timing relation is exact in core cycles. Raising the enable starts both dividers and the detector from a cleared, aligned state. Dropping it lets any up or down pulse already in flight run to its natural end before everything stops. A new ratio or reference code is picked up only when a divider wraps. The offset arrives as a 7-bit field in register order: its most significant bit sits at field bit 5 and its least significant bit sits at field bit 6.

Top module: `pll_core`

## Requirements
- R1: The main divider emits one strobe every 2176+n counted RF ticks. n is unsigned, with n = {prog_word_i[5:0], prog_word_i[6]}, so prog_word_i[5] is the MSB of n and prog_word_i[6] is its LSB.
- R2: The reference divider emits one strobe every R counted reference ticks, where ref_sel_i codes 00, 01, 10 and 11 select R = 4, 16, 8 and 12 respectively.
- R3: When a reference strobe comes d core cycles before the main strobe, up_o goes high one cycle after the reference strobe and stays high for d+OVERLAP_CYC cycles, while dn_o is high for OVERLAP_CYC cycles only.
- R4: When a main strobe comes d core cycles before the reference strobe, dn_o is high for d+OVERLAP_CYC cycles and up_o is high for OVERLAP_CYC cycles. If the two strobes coincide, each output is high for OVERLAP_CYC cycles.
- R5: up_o and dn_o are high together for exactly OVERLAP_CYC cycles per comparison (default 2), and then both fall in the same cycle.
- R6: Both dividers start from zero when enabled. With ticks counted from the first core cycle after enable is registered, the first main strobe is seen M cycles later and the first reference strobe follows the R-th reference tick by one cycle.
- R7: While en_i is low and no pulse is in flight, the dividers are held, so no strobes appear and up_o and dn_o stay low even though ticks arrive.
- R8: When en_i drops while up_o or dn_o is high, the dividers and detector keep running until that pulse ends with its normal overlap. After that nothing further is produced.
- R9: A new offset or reference code that arrives mid-count does not change the period in progress. It takes effect from the next wrap of that divider.
- R10: Each divider strobe is a single-cycle pulse, seen one core cycle after the tick that completes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Synthesizer enable |
| rf_tick_i | input | 1 | One-cycle strobe per prescaled RF edge |
| ref_tick_i | input | 1 | One-cycle strobe per crystal edge |
| prog_word_i | input | 7 | Main offset field in register bit order (see R1) |
| ref_sel_i | input | 2 | Reference ratio code (see R2) |
| up_o | output | 1 | Charge-pump source request |
| dn_o | output | 1 | Charge-pump sink request |
| main_strobe_o | output | 1 | Main divider wrap strobe |
| ref_strobe_o | output | 1 | Reference divider wrap strobe |

## Verification
The bench places the reference edge a few cycles before the main edge, a few cycles after it, and exactly on it. For each case it checks the up and down widths and the overlap length. A swapped polarity or a lost overlap shows up as wrong widths, and a detector with no overlap leaves a dead zone. The offset test uses the extreme values and a value whose LSB sits in field bit 6, so a divider that reads the field as a plain binary number misses the first strobe cycle. The non-monotonic reference codes are all used, so a straight binary decode gives the wrong reference strobe time. Further tests drop enable in the middle of a long up pulse, where a design that stops at once truncates the pulse and leaves the down edge missing, and change the ratio and code mid-count, where a design that loads immediately moves the current strobe.

// File: rtl/pll_pkg.sv
package pll_pkg;

  localparam int REF_RATIO_W = 5;

  // code order is not monotonic in ratio
  function automatic logic [REF_RATIO_W-1:0] ref_ratio_f(input logic [1:0] code);
    logic [REF_RATIO_W-1:0] r;
    case (code)
      2'b00:   r = REF_RATIO_W'(4);
      2'b01:   r = REF_RATIO_W'(16);
      2'b10:   r = REF_RATIO_W'(8);
      default: r = REF_RATIO_W'(12);
    endcase
    return r;
  endfunction

  // offset field: bit OFF_W-1 carries the LSB, the rest are MSB-first
  function automatic logic [6:0] off_unpack_f(input logic [6:0] word);
    return {word[5:0], word[6]};
  endfunction

endpackage

// File: rtl/pll_prog_div.sv
module pll_prog_div #(
  parameter int RATIO_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               strobe_o
);

  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] ratio_q;
  logic               term;

  assign term = tick_i && (cnt_q == ratio_q - RATIO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      ratio_q  <= '1;
      strobe_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q    <= '0;
      ratio_q  <= ratio_i;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= term;
      if (term) begin
        cnt_q   <= '0;
        ratio_q <= ratio_i;
      end else if (tick_i) begin
        cnt_q <= cnt_q + RATIO_W'(1);
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < ratio_q)); // R1

  AST_RATIO_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && !$stable(ratio_q)) |-> strobe_o); // R9

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o); // R10

  AST_STROBE_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $past(run_i)); // R7

endmodule

// File: rtl/pll_pfd.sv
module pll_pfd #(
  parameter int OVERLAP_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic en_i,
  input  logic main_edge_i,
  input  logic ref_edge_i,
  output logic up_o,
  output logic dn_o
);

  localparam int OVL_W = $clog2(OVERLAP_CYC + 1);

  logic [OVL_W-1:0] ovl_q;
  logic             both;
  logic             clr;
  logic             accept;

  assign both   = up_o && dn_o;
  assign clr    = both && (ovl_q == OVL_W'(OVERLAP_CYC - 1));
  // after disable only the closing edge of a live pulse is taken
  assign accept = en_i || ((up_o || dn_o) && !clr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_o  <= 1'b0;
      dn_o  <= 1'b0;
      ovl_q <= '0;
    end else if (!run_i) begin
      up_o  <= 1'b0;
      dn_o  <= 1'b0;
      ovl_q <= '0;
    end else begin
      up_o  <= (up_o && !clr) || (ref_edge_i && accept);
      dn_o  <= (dn_o && !clr) || (main_edge_i && accept);
      ovl_q <= (both && !clr) ? ovl_q + OVL_W'(1) : '0;
    end
  end

  AST_UP_ENDS_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(up_o) |-> $past(dn_o)); // R8

  AST_DN_ENDS_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dn_o) |-> $past(up_o)); // R5

  AST_FALL_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(up_o) && $past(dn_o) && !up_o) |-> !dn_o); // R5

endmodule

// File: rtl/pll_core.sv
module pll_core #(
  parameter int MAIN_BASE   = 2176,
  parameter int OFF_W       = 7,
  parameter int OVERLAP_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rf_tick_i,
  input  logic             ref_tick_i,
  input  logic [OFF_W-1:0] prog_word_i,
  input  logic [1:0]       ref_sel_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             main_strobe_o,
  output logic             ref_strobe_o
);

  localparam int MAIN_W = $clog2(MAIN_BASE + (1 << OFF_W));
  localparam int REF_W  = pll_pkg::REF_RATIO_W;

  logic [OFF_W-1:0]  off_n;
  logic [MAIN_W-1:0] main_ratio;
  logic [REF_W-1:0]  ref_ratio;
  logic              run_q;

  assign off_n      = {prog_word_i[OFF_W-2:0], prog_word_i[OFF_W-1]};
  assign main_ratio = MAIN_W'(MAIN_BASE) + MAIN_W'(off_n);
  assign ref_ratio  = pll_pkg::ref_ratio_f(ref_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i || up_o || dn_o;
  end

  pll_prog_div #(.RATIO_W(MAIN_W)) u_main_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .tick_i   (rf_tick_i),
    .ratio_i  (main_ratio),
    .strobe_o (main_strobe_o)
  );

  pll_prog_div #(.RATIO_W(REF_W)) u_ref_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .tick_i   (ref_tick_i),
    .ratio_i  (ref_ratio),
    .strobe_o (ref_strobe_o)
  );

  pll_pfd #(.OVERLAP_CYC(OVERLAP_CYC)) u_pfd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_q),
    .en_i        (en_i),
    .main_edge_i (main_strobe_o),
    .ref_edge_i  (ref_strobe_o),
    .up_o        (up_o),
    .dn_o        (dn_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (!up_o && !dn_o && !main_strobe_o && !ref_strobe_o)); // R7

  AST_DRAIN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o || dn_o) |=> run_q); // R8

endmodule

// File: tb/pll_core_test.sv
module pll_core_test;

  localparam int OVL = 2;
  localparam int NV  = 6;
  localparam int LEN = 5000;

  // n, ref code, ref tick spacing, ref tick offset
  localparam int V_N  [NV] = '{0, 0, 0, 8, 127, 47};
  localparam int V_SEL[NV] = '{0, 1, 2, 3, 0, 0};
  localparam int V_P  [NV] = '{544, 136, 272, 182, 576, 556};
  localparam int V_O  [NV] = '{538, 139, 271, 172, 570, 560};

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en = 1'b0;
  logic       rf_tick = 1'b0;
  logic       ref_tick = 1'b0;
  logic [6:0] prog_word = '0;
  logic [1:0] ref_sel = '0;
  logic       up, dn, ms, rs;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int ms_idx[3];
  int rs_idx[3];
  int ms_tot, rs_tot, up_cnt, dn_cnt, both_cnt, late_act;

  always #2 clk = ~clk;

  pll_core uut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .en_i          (en),
    .rf_tick_i     (rf_tick),
    .ref_tick_i    (ref_tick),
    .prog_word_i   (prog_word),
    .ref_sel_i     (ref_sel),
    .up_o          (up),
    .dn_o          (dn),
    .main_strobe_o (ms),
    .ref_strobe_o  (rs)
  );

  function automatic logic [6:0] enc(input int n);
    logic [6:0] v;
    v = 7'(n);
    return {v[0], v[6:1]};
  endfunction

  function automatic int bref(input int s);
    case (s)
      0: return 4;
      1: return 16;
      2: return 8;
      default: return 12;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input int n, input int sel, input int p, input int o,
                          input int drop_at, input int sel_at, input int sel_new,
                          input int n_at, input int n_new, input int len,
                          input int win_end, input int late_from);
    for (int k = 0; k < 3; k++) begin ms_idx[k] = -1; rs_idx[k] = -1; end
    ms_tot = 0; rs_tot = 0; up_cnt = 0; dn_cnt = 0; both_cnt = 0; late_act = 0;
    @(negedge clk);
    prog_word = enc(n);
    ref_sel   = 2'(sel);
    en        = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (ms) begin if (ms_tot < 3) ms_idx[ms_tot] = i; ms_tot++; end
      if (rs) begin if (rs_tot < 3) rs_idx[rs_tot] = i; rs_tot++; end
      if (i <= win_end) begin
        if (up) up_cnt++;
        if (dn) dn_cnt++;
        if (up && dn) both_cnt++;
      end
      if (i >= late_from && (up || dn || ms || rs)) late_act++;
      rf_tick  = 1'b1;
      ref_tick = (i >= o) && ((i - o) % p == 0);
      if (i == drop_at) en = 1'b0;
      if (i == sel_at) ref_sel = 2'(sel_new);
      if (i == n_at) prog_word = enc(n_new);
    end
    @(negedge clk);
    en = 1'b0; rf_tick = 1'b1; ref_tick = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      if (!up && !dn) break;
      @(negedge clk);
    end
    rf_tick = 1'b0; ref_tick = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7", "reset up", int'(up), 0);
    chk("R7", "reset dn", int'(dn), 0);
    chk("R7", "reset strobes", int'(ms | rs), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // table of phase cases
    for (int v = 0; v < NV; v++) begin
      int m1, r1, dt, rp, we;
      m1 = 2176 + V_N[v];
      rp = bref(V_SEL[v]) * V_P[v];
      r1 = V_O[v] + (bref(V_SEL[v]) - 1) * V_P[v] + 1;
      dt = m1 - r1;
      we = ((m1 > r1) ? m1 : r1) + OVL + 3;
      run_case(V_N[v], V_SEL[v], V_P[v], V_O[v], -1, -1, 0, -1, 0, LEN, we, LEN);
      chk("R1", "first main strobe", ms_idx[0], m1);
      chk("R1", "main period", ms_idx[1] - ms_idx[0], m1);
      chk("R2", "first ref strobe", rs_idx[0], r1);
      chk("R2", "ref period", rs_idx[1] - rs_idx[0], rp);
      chk("R10", "main strobe cycles", ms_tot, 2);
      chk("R10", "ref strobe cycles", rs_tot, 2);
      chk("R5", "overlap cycles", both_cnt, OVL);
      if (dt >= 0) begin
        chk("R3", "up width", up_cnt, dt + OVL);
        chk("R3", "dn width", dn_cnt, OVL);
      end else begin
        chk("R4", "dn width", dn_cnt, -dt + OVL);
        chk("R4", "up width", up_cnt, OVL);
      end
    end

    // disable in the middle of a long up pulse
    run_case(0, 0, 544, 500, 2134, -1, 0, -1, 0, LEN, 2200, 2200);
    chk("R8", "main strobe after disable", ms_idx[0], 2176);
    chk("R8", "up width kept", up_cnt, 2176 - 2133 + OVL);
    chk("R8", "dn closing pulse", dn_cnt, OVL);
    chk("R8", "activity after drain", late_act, 0);

    // mid-count change of reference code and offset
    run_case(0, 0, 10, 0, -1, 35, 1, 1000, 100, 4600, -1, 4600);
    chk("R9", "ref strobe 1", rs_idx[0], 31);
    chk("R9", "ref strobe 2 old ratio", rs_idx[1], 71);
    chk("R9", "ref strobe 3 new ratio", rs_idx[2], 231);
    chk("R9", "main strobe 1 old ratio", ms_idx[0], 2176);
    chk("R9", "main strobe 2 new ratio", ms_idx[1], 2176 + 2276);
    chk("R6", "ref strobe after restart", rs_idx[0], 31);

    // ticks while disabled
    begin
      int act;
      act = 0;
      en = 1'b0; rf_tick = 1'b1; ref_tick = 1'b1;
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        if (up || dn || ms || rs) act++;
      end
      rf_tick = 1'b0; ref_tick = 1'b0;
      chk("R7", "activity while disabled", act, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule